// File: doc/BRIEF.md
# Lockstep Duplex Comparator Controller

This block supervises a pair of processors, unit A and unit B, that execute the same instruction stream in lockstep. While the pair is coupled, each unit presents a result word with a valid strobe every cycle, and the block compares the two. Exactly one unit, the active one, is selected to drive the controlled system. The other runs as a synchronized shadow with no control outputs.

When the comparison fails, the block decouples the pair and asks both units to run a check-out routine. It collects a pass/fail verdict from each unit and retires the unit found faulty. A unit that gives no verdict within a configurable number of cycles is treated as faulty. If both units pass, the fault cannot be attributed and a policy input chooses the outcome. After a repair, a request starts re-integration. The active unit's memory is copied to the repaired unit, the repaired unit is brought into step, and only then is the comparator turned on again.

Result words are taken without back-pressure. The block has no ready output: it samples both strobes and both words on every clock edge, and a unit cannot stall it. Control and status pins are plain levels or one-cycle pulses.

Top module: `lockstep_duplex_ctrl`

## Requirements
- R1: After reset the block is in state COUPLED (status code 0). Unit A is active (status_active = 0), cmp_en = 1, fault_cause = 0, in_service = 2'b11 and ctrl_sel = 2'b01. chk_req, copy_req and sync_req are all low. Bit 0 of every two-bit unit vector is unit A and bit 1 is unit B.
- R2: In COUPLED, a cycle with both strobes high and different words moves the block to DECOUPLED_CHECK (code 1) at the next edge and sets fault_cause bit 0 (data difference). Cycles with equal words, or with both strobes low, leave the state unchanged.
- R3: In COUPLED, a cycle with exactly one strobe high moves the block to DECOUPLED_CHECK and sets fault_cause bit 1 (strobe skew).
- R4: In DECOUPLED_CHECK, chk_req = 2'b11, ctrl_sel = 2'b00 and cmp_en = 0. The first chk_done pulse from each unit latches that unit's verdict, with chk_pass high meaning pass. The block decides only once both verdicts are held, counting a verdict that arrives in the same cycle.
- R5: If exactly one unit is found faulty, the block goes to SIMPLEX on the other unit and makes that unit active. SIMPLEX_A is code 2 and SIMPLEX_B is code 3. in_service and ctrl_sel then show only the surviving unit.
- R6: If both units are found faulty, the block continues in SIMPLEX on the unit that was active, and the active unit does not change.
- R7: If the block has spent TIMEOUT_CYC cycles in DECOUPLED_CHECK without holding both verdicts, it decides at the end of the last of those cycles. Any unit without a verdict is treated as faulty, and fault_cause bit 2 (timeout) is set.
- R8: If both units pass, policy selects the action. 2'b00 keeps both units: the block returns to COUPLED with the active unit unchanged. 2'b01 retires the active unit: the block goes to SIMPLEX on the other unit, which becomes active. 2'b10 and 2'b11 continue on the active unit alone.
- R9: In SIMPLEX, a reint_req pulse moves the block to REINT_COPY (code 4) with copy_req high. A copy_done pulse then moves it to REINT_SYNC (code 5) with sync_req high. A sync_done pulse then moves it to COUPLED with cmp_en = 1 and in_service = 2'b11. cmp_en stays low in every state except COUPLED.
- R10: fault_cause bits are sticky. They accumulate across check-out rounds that end with keep-both, and they clear only when re-integration completes.
- R11: reint_req, copy_done and sync_done have no effect outside the state that consumes them. Strobes and words have no effect outside COUPLED.
- R12: ctrl_sel is one-hot on the active unit in every state except DECOUPLED_CHECK, where it is 2'b00. The active unit changes only when the block leaves DECOUPLED_CHECK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Unit A result strobe |
| a_data | input | DATA_W | Unit A result word |
| b_valid | input | 1 | Unit B result strobe |
| b_data | input | DATA_W | Unit B result word |
| policy | input | 2 | Action when both units pass check-out |
| chk_req | output | 2 | Check-out request per unit |
| chk_done | input | 2 | Verdict pulse per unit |
| chk_pass | input | 2 | Verdict value per unit, 1 = pass |
| reint_req | input | 1 | Repaired unit is ready to rejoin |
| copy_req | output | 1 | Copy active memory to the repaired unit |
| copy_done | input | 1 | Memory copy finished |
| sync_req | output | 1 | Bring the repaired unit into step |
| sync_done | input | 1 | Repaired unit is in step |
| cmp_en | output | 1 | Comparator is enabled |
| ctrl_sel | output | 2 | Unit driving the controlled system |
| in_service | output | 2 | Units currently in service |
| status_state | output | 3 | Current state code |
| status_active | output | 1 | Active unit, 0 = A, 1 = B |
| fault_cause | output | 3 | Sticky cause: bit0 data, bit1 skew, bit2 timeout |

## Verification
The hardest situation to reach is a timeout where one unit has already given its verdict and the other stays silent. In that case the decision must fall on exactly the TIMEOUT_CYC-th cycle of check-out, not one cycle earlier or later. The bench builds the block with a small timeout and delivers a single pass verdict. It then withholds the second verdict, checks that the state is still check-out one cycle before the limit, and checks the retirement and the timeout bit at the limit. Unattributable mismatches, where both units pass, are reached with the same stimulus under each policy code. The sticky cause bits are tested by chaining a keep-both round into a second mismatch before any re-integration.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

  typedef enum logic [2:0] {
    ST_COUPLED    = 3'd0,
    ST_CHECK      = 3'd1,
    ST_SIMPLEX_A  = 3'd2,
    ST_SIMPLEX_B  = 3'd3,
    ST_REINT_COPY = 3'd4,
    ST_REINT_SYNC = 3'd5
  } ldc_state_e;

  typedef struct packed {
    logic timeout;
    logic skew;
    logic data;
  } ldc_cause_t;

  localparam logic [1:0] POL_KEEP_BOTH = 2'd0;
  localparam logic [1:0] POL_SWAP      = 2'd1;

  localparam int UNITS = 2;

  function automatic ldc_state_e simplex_of(input logic unit_b);
    return unit_b ? ST_SIMPLEX_B : ST_SIMPLEX_A;
  endfunction

endpackage

// File: rtl/ldc_compare.sv
module ldc_compare #(
  parameter int DATA_W = 32
) (
  input  logic              en,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_data,
  output logic              data_mis,
  output logic              skew_mis
);

  logic both_valid;
  logic words_differ;

  assign both_valid   = a_valid & b_valid;
  assign words_differ = |(a_data ^ b_data);

  // a lone strobe is a skew; data are judged only when both strobes agree
  assign skew_mis = en & (a_valid ^ b_valid);
  assign data_mis = en & both_valid & words_differ;

endmodule

// File: rtl/ldc_checkout.sv
module ldc_checkout #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] done,
  input  logic [1:0] pass,
  output logic       decide,
  output logic [1:0] faulty,
  output logic       timed_out
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] timer_q;
  logic [1:0]    eff_got;
  logic          all_in;
  logic          limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      timer_q <= '0;
    else if (!run)   timer_q <= '0;
    else             timer_q <= timer_q + 1'b1;
  end

  for (genvar u = 0; u < 2; u++) begin : g_unit
    logic got_q;
    logic fail_q;
    logic eff_fail;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        got_q  <= 1'b0;
        fail_q <= 1'b0;
      end else if (!run) begin
        got_q  <= 1'b0;
        fail_q <= 1'b0;
      end else if (done[u] && !got_q) begin
        got_q  <= 1'b1;
        fail_q <= ~pass[u];
      end
    end

    assign eff_got[u] = got_q | done[u];
    assign eff_fail   = got_q ? fail_q : ~pass[u];
    // silence at decision time counts as a fault
    assign faulty[u]  = eff_got[u] ? eff_fail : 1'b1;
  end

  assign all_in    = &eff_got;
  assign limit     = (timer_q == LAST);
  assign decide    = run & (all_in | limit);
  assign timed_out = run & limit & ~all_in;

endmodule

// File: rtl/ldc_supervisor.sv
module ldc_supervisor
  import ldc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_mis,
  input  logic       skew_mis,
  input  logic       decide,
  input  logic [1:0] faulty,
  input  logic       timed_out,
  input  logic [1:0] policy,
  input  logic       reint_req,
  input  logic       copy_done,
  input  logic       sync_done,
  output ldc_state_e state_q,
  output logic       active_b_q,
  output ldc_cause_t cause_q
);

  ldc_state_e state_d;
  logic       active_b_d;
  ldc_cause_t cause_d;

  always_comb begin
    state_d    = state_q;
    active_b_d = active_b_q;
    cause_d    = cause_q;
    unique case (state_q)
      ST_COUPLED: begin
        if (data_mis || skew_mis) begin
          state_d      = ST_CHECK;
          cause_d.data = cause_q.data | data_mis;
          cause_d.skew = cause_q.skew | skew_mis;
        end
      end
      ST_CHECK: begin
        if (decide) begin
          if (timed_out) cause_d.timeout = 1'b1;
          if (faulty[0] && !faulty[1]) begin
            state_d    = ST_SIMPLEX_B;
            active_b_d = 1'b1;
          end else if (faulty[1] && !faulty[0]) begin
            state_d    = ST_SIMPLEX_A;
            active_b_d = 1'b0;
          end else if (&faulty) begin
            state_d = simplex_of(active_b_q);
          end else if (policy == POL_KEEP_BOTH) begin
            state_d = ST_COUPLED;
          end else if (policy == POL_SWAP) begin
            state_d    = simplex_of(~active_b_q);
            active_b_d = ~active_b_q;
          end else begin
            state_d = simplex_of(active_b_q);
          end
        end
      end
      ST_SIMPLEX_A, ST_SIMPLEX_B: begin
        if (reint_req) state_d = ST_REINT_COPY;
      end
      ST_REINT_COPY: begin
        if (copy_done) state_d = ST_REINT_SYNC;
      end
      ST_REINT_SYNC: begin
        if (sync_done) begin
          state_d = ST_COUPLED;
          cause_d = '0;
        end
      end
      default: state_d = ST_COUPLED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_COUPLED;
      active_b_q <= 1'b0;
      cause_q    <= '0;
    end else begin
      state_q    <= state_d;
      active_b_q <= active_b_d;
      cause_q    <= cause_d;
    end
  end

endmodule

// File: rtl/lockstep_duplex_ctrl.sv
module lockstep_duplex_ctrl
  import ldc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_data,
  input  logic [1:0]        policy,
  output logic [1:0]        chk_req,
  input  logic [1:0]        chk_done,
  input  logic [1:0]        chk_pass,
  input  logic              reint_req,
  output logic              copy_req,
  input  logic              copy_done,
  output logic              sync_req,
  input  logic              sync_done,
  output logic              cmp_en,
  output logic [1:0]        ctrl_sel,
  output logic [1:0]        in_service,
  output logic [2:0]        status_state,
  output logic              status_active,
  output logic [2:0]        fault_cause
);

  ldc_state_e state_q;
  logic       active_b_q;
  ldc_cause_t cause_q;
  logic       data_mis, skew_mis;
  logic       decide, timed_out;
  logic [1:0] faulty;
  logic       in_check;
  logic [1:0] active_hot;

  assign in_check = (state_q == ST_CHECK);

  ldc_compare #(.DATA_W(DATA_W)) u_cmp (
    .en       (cmp_en),
    .a_valid  (a_valid),
    .a_data   (a_data),
    .b_valid  (b_valid),
    .b_data   (b_data),
    .data_mis (data_mis),
    .skew_mis (skew_mis)
  );

  ldc_checkout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (in_check),
    .done      (chk_done),
    .pass      (chk_pass),
    .decide    (decide),
    .faulty    (faulty),
    .timed_out (timed_out)
  );

  ldc_supervisor u_sup (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_mis   (data_mis),
    .skew_mis   (skew_mis),
    .decide     (decide),
    .faulty     (faulty),
    .timed_out  (timed_out),
    .policy     (policy),
    .reint_req  (reint_req),
    .copy_done  (copy_done),
    .sync_done  (sync_done),
    .state_q    (state_q),
    .active_b_q (active_b_q),
    .cause_q    (cause_q)
  );

  assign active_hot = active_b_q ? 2'b10 : 2'b01;

  assign cmp_en        = (state_q == ST_COUPLED);
  assign chk_req       = in_check ? 2'b11 : 2'b00;
  assign copy_req      = (state_q == ST_REINT_COPY);
  assign sync_req      = (state_q == ST_REINT_SYNC);
  assign ctrl_sel      = in_check ? 2'b00 : active_hot;
  assign in_service    = (cmp_en || in_check) ? 2'b11 : active_hot;
  assign status_state  = state_q;
  assign status_active = active_b_q;
  assign fault_cause   = cause_q;

endmodule

// File: rtl/ldc_checker.sv
module ldc_checker
  import ldc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 4096
) (
  input logic       clk,
  input logic       rst_n,
  input logic       a_valid,
  input logic       b_valid,
  input logic       copy_done,
  input logic       cmp_en,
  input logic [1:0] ctrl_sel,
  input logic [2:0] status_state,
  input logic       status_active,
  input logic [2:0] fault_cause
);

  logic [31:0] dwell_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        dwell_q <= '0;
    else if (status_state == ST_CHECK) dwell_q <= dwell_q + 1;
    else                               dwell_q <= '0;
  end

  p_skew_enters_check_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_state == ST_COUPLED && (a_valid != b_valid)) |=> (status_state == ST_CHECK && fault_cause[1]));

  p_dwell_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_state == ST_CHECK) |-> (dwell_q < TIMEOUT_CYC));

  p_ctrl_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_sel) && ((status_state == ST_CHECK) || $countones(ctrl_sel) == 1));

  p_active_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_state != ST_CHECK) |=> $stable(status_active));

  p_copy_to_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_state == ST_REINT_COPY && copy_done) |=> (status_state == ST_REINT_SYNC));

  p_cmp_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_en) |-> ($past(status_state) == ST_CHECK || $past(status_state) == ST_REINT_SYNC));

  p_cause_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_state) == ST_REINT_SYNC && status_state == ST_COUPLED) |-> (fault_cause == 3'b000));

endmodule

bind lockstep_duplex_ctrl ldc_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ldc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .a_valid       (a_valid),
  .b_valid       (b_valid),
  .copy_done     (copy_done),
  .cmp_en        (cmp_en),
  .ctrl_sel      (ctrl_sel),
  .status_state  (status_state),
  .status_active (status_active),
  .fault_cause   (fault_cause)
);

// File: tb/lockstep_duplex_ctrl_tb_top.sv
module lockstep_duplex_ctrl_tb_top;

  localparam int DW  = 16;
  localparam int TMO = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_valid = 1'b0, b_valid = 1'b0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic [1:0]    policy = 2'd0;
  logic [1:0]    chk_done = 2'b00, chk_pass = 2'b00;
  logic          reint_req = 1'b0, copy_done = 1'b0, sync_done = 1'b0;
  logic [1:0]    chk_req, ctrl_sel, in_service;
  logic          copy_req, sync_req, cmp_en, status_active;
  logic [2:0]    status_state, fault_cause;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #5 clk = ~clk;

  lockstep_duplex_ctrl #(.DATA_W(DW), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_data(a_data), .b_valid(b_valid), .b_data(b_data),
    .policy(policy), .chk_req(chk_req), .chk_done(chk_done), .chk_pass(chk_pass),
    .reint_req(reint_req), .copy_req(copy_req), .copy_done(copy_done),
    .sync_req(sync_req), .sync_done(sync_done), .cmp_en(cmp_en),
    .ctrl_sel(ctrl_sel), .in_service(in_service), .status_state(status_state),
    .status_active(status_active), .fault_cause(fault_cause)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: state 0 coupled, 1 check, 2/3 simplex A/B, 4 copy, 5 sync
  int m_state, m_act, m_cause, m_timer;
  bit m_got[2];
  bit m_bad[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_act = 0; m_cause = 0; m_timer = 0;
      m_got = '{0, 0}; m_bad = '{0, 0};
    end else begin
      case (m_state)
        0: begin
          if (a_valid != b_valid) begin m_cause |= 2; m_state = 1; end
          else if (a_valid && a_data != b_data) begin m_cause |= 1; m_state = 1; end
          m_timer = 0; m_got = '{0, 0}; m_bad = '{0, 0};
        end
        1: begin
          bit g[2];
          bit f[2];
          bit x[2];
          for (int u = 0; u < 2; u++) begin
            g[u] = m_got[u] || chk_done[u];
            f[u] = m_got[u] ? m_bad[u] : !chk_pass[u];
            x[u] = g[u] ? f[u] : 1'b1;
          end
          if ((g[0] && g[1]) || m_timer == TMO - 1) begin
            if (!(g[0] && g[1])) m_cause |= 4;
            if (x[0] && !x[1]) begin m_state = 3; m_act = 1; end
            else if (x[1] && !x[0]) begin m_state = 2; m_act = 0; end
            else if (x[0] && x[1]) m_state = 2 + m_act;
            else if (policy == 0) m_state = 0;
            else if (policy == 1) begin m_act = 1 - m_act; m_state = 2 + m_act; end
            else m_state = 2 + m_act;
          end else begin
            for (int u = 0; u < 2; u++)
              if (!m_got[u] && chk_done[u]) begin m_got[u] = 1; m_bad[u] = !chk_pass[u]; end
            m_timer++;
          end
        end
        2, 3: if (reint_req) m_state = 4;
        4: if (copy_done) m_state = 5;
        5: if (sync_done) begin m_state = 0; m_cause = 0; end
        default: m_state = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int hot;
      hot = (m_act == 1) ? 2 : 1;
      chk("R4", "model state", int'(status_state), m_state);
      chk("R12", "model active", int'(status_active), m_act);
      chk("R10", "model cause", int'(fault_cause), m_cause);
      chk("R12", "model ctrl_sel", int'(ctrl_sel), (m_state == 1) ? 0 : hot);
      chk("R5", "model in_service", int'(in_service), (m_state <= 1) ? 3 : hot);
      chk("R9", "model cmp_en", int'(cmp_en), int'(m_state == 0));
      chk("R9", "model copy_req", int'(copy_req), int'(m_state == 4));
      chk("R9", "model sync_req", int'(sync_req), int'(m_state == 5));
      chk("R4", "model chk_req", int'(chk_req), (m_state == 1) ? 3 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=finish", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic data_mis();
    a_valid = 1; b_valid = 1; a_data = 16'h1234; b_data = 16'h1235;
    tick();
    a_valid = 0; b_valid = 0;
  endtask

  task automatic verdict(input logic [1:0] d, input logic [1:0] p);
    chk_done = d; chk_pass = p;
    tick();
    chk_done = 0; chk_pass = 0;
  endtask

  task automatic pulse_reint(); reint_req = 1; tick(); reint_req = 0; endtask
  task automatic pulse_copy();  copy_done = 1; tick(); copy_done = 0; endtask
  task automatic pulse_sync();  sync_done = 1; tick(); sync_done = 0; endtask

  task automatic rejoin();
    pulse_reint(); pulse_copy(); pulse_sync();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1", "state", status_state, 0);
    chk("R1", "active", status_active, 0);
    chk("R1", "cmp_en", cmp_en, 1);
    chk("R1", "cause", fault_cause, 0);
    chk("R1", "in_service", in_service, 3);
    chk("R1", "ctrl_sel", ctrl_sel, 1);
    chk("R1", "reqs", {chk_req, copy_req, sync_req}, 0);

    // R2 equal words keep the pair coupled
    for (int i = 0; i < 4; i++) begin
      a_valid = 1; b_valid = 1; a_data = DW'(i * 77); b_data = DW'(i * 77);
      tick();
    end
    a_valid = 0; b_valid = 0; tick();
    chk("R2", "state equal words", status_state, 0);

    // R2 data mismatch, then R11 skew ignored in check, R4 partial verdict, R5 retire A
    data_mis();
    chk("R2", "state after mismatch", status_state, 1);
    chk("R2", "cause data", fault_cause, 1);
    chk("R4", "ctrl_sel in check", ctrl_sel, 0);
    a_valid = 1; tick(); a_valid = 0;
    chk("R11", "cause after skew in check", fault_cause, 1);
    verdict(2'b01, 2'b00);
    chk("R4", "wait for second verdict", status_state, 1);
    verdict(2'b10, 2'b10);
    chk("R5", "simplex B", status_state, 3);
    chk("R5", "active B", status_active, 1);
    chk("R5", "in_service", in_service, 2);

    // R11 stray pulses, R9 staged re-integration
    pulse_copy();
    chk("R11", "copy_done in simplex", status_state, 3);
    pulse_reint();
    chk("R9", "copy stage", status_state, 4);
    chk("R9", "copy_req", copy_req, 1);
    pulse_sync();
    chk("R11", "sync_done in copy", status_state, 4);
    pulse_copy();
    chk("R9", "sync stage", status_state, 5);
    chk("R9", "cmp_en off in sync", cmp_en, 0);
    pulse_sync();
    chk("R9", "coupled again", status_state, 0);
    chk("R9", "in_service both", in_service, 3);
    chk("R10", "cause cleared", fault_cause, 0);

    // R3 skew, R8 keep both, R10 sticky accumulation
    b_valid = 1; tick(); b_valid = 0;
    chk("R3", "state after skew", status_state, 1);
    chk("R3", "cause skew", fault_cause, 2);
    policy = 2'd0;
    verdict(2'b11, 2'b11);
    chk("R8", "keep both", status_state, 0);
    chk("R8", "active kept B", status_active, 1);
    chk("R10", "cause sticky", fault_cause, 2);
    data_mis();
    chk("R10", "cause accumulates", fault_cause, 3);
    policy = 2'd1;
    verdict(2'b11, 2'b11);
    chk("R8", "swap to A", status_state, 2);
    chk("R8", "active A", status_active, 0);
    rejoin();

    // R11 reint_req ignored while coupled
    pulse_reint();
    chk("R11", "reint in coupled", status_state, 0);

    // R7 timeout with B silent
    data_mis();
    verdict(2'b01, 2'b01);
    repeat (TMO - 2) tick();
    chk("R7", "still in check before limit", status_state, 1);
    tick();
    chk("R7", "retire silent B", status_state, 2);
    chk("R7", "cause timeout", fault_cause, 5);
    rejoin();

    // R6 both fail keeps the active unit
    data_mis();
    verdict(2'b11, 2'b00);
    chk("R6", "both fail", status_state, 2);
    chk("R6", "active unchanged", status_active, 0);
    rejoin();

    // R8 policy 10 and 11 continue on the active unit
    policy = 2'd2;
    data_mis();
    verdict(2'b11, 2'b11);
    chk("R8", "policy 10", status_state, 2);
    rejoin();
    policy = 2'd3;
    data_mis();
    verdict(2'b11, 2'b11);
    chk("R8", "policy 11", status_state, 2);
    rejoin();

    // R5 B faulty, A passes
    data_mis();
    verdict(2'b11, 2'b01);
    chk("R5", "retire B", status_state, 2);
    chk("R12", "ctrl_sel A", ctrl_sel, 1);
    rejoin();

    // R7 neither unit answers: both faulty, stay on active
    data_mis();
    repeat (TMO) tick();
    chk("R7", "both silent", status_state, 2);
    chk("R7", "cause timeout data", fault_cause, 5);
    rejoin();

    tick();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule